// File: doc/BRIEF.md
# Multi-mode 16-bit reload timer

This block is a 16-bit timer/counter whose count is held as two cascaded byte halves. A 16-bit reload register goes with it. A small register port loads and reads both, plus a two-bit flag register. The count source is either a fixed divide of the system clock or the falling edges of an external count pin.

The block has three modes:

- **Auto-reload.** It counts up, and on passing the all-ones value it takes the reload value and raises the overflow flag. Optionally a second external pin picks the count direction. In that case the wrap rules differ by direction, and the external flag toggles on every wrap as a seventeenth count bit.
- **Baud generation.** The count runs six times faster. Each rollover reloads the counter and emits a one-clock baud tick, but never sets the overflow flag.
- **Clock output.** It uses the same fast rollover to toggle an output pin, giving a 50% duty clock.

Baud generation and clock output may run together, and they then share one reload value.

Top module: `mmode_timer16`

## Requirements
- R1: After reset the count, the reload register, both flags, `baud_tick` and `clk_out` are zero.
- R2: Register addresses are: 0 is the count low byte, 1 the count high byte, 2 the reload low byte, 3 the reload high byte, and 4 the flags (bit 0 overflow, bit 1 external). A write lands on the next clock edge and takes precedence over counting in that cycle. A read is combinational.
- R3: With `cnt_sel` low and neither fast mode active, the count advances once every 12 clocks while `run_en` is high. It holds while `run_en` is low.
- R4: With `cnt_sel` high, each falling edge of `cnt_pin` advances the count once, after a two-flop synchronizer. Edges are ignored while `run_en` is low.
- R5: In auto-reload mode an up-count step taken at all-ones loads the reload value and sets the overflow flag. With up/down off, the external flag is left alone.
- R6: With `updn_en` high in auto-reload mode, a low synchronized `ext_pin` counts down. A step taken when the count equals the reload value loads all-ones, sets the overflow flag and toggles the external flag. A high `ext_pin` counts up, and its rollover also toggles the external flag.
- R7: Baud mode (`baud_en`), and clock-out mode (`clkout_en` with `cnt_sel` low), count once every 2 clocks. Their rollover reloads the count and never sets the overflow flag.
- R8: In baud mode `baud_tick` pulses for one clock on each rollover. The pulse period is (65536 - reload) * 2 clocks.
- R9: In clock-out mode `clk_out` toggles on each rollover, so its half-period equals the baud tick period for the same reload value. `clk_out` changes in no other mode.
- R10: When up/down counting is not active and `ext_en` is high, a synchronized falling edge of `ext_pin` sets the external flag and does not reload the count. When `ext_en` is low, such an edge leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counting enable |
| cnt_sel | input | 1 | 1: count `cnt_pin` falling edges, 0: count divided clock |
| updn_en | input | 1 | Direction taken from `ext_pin` in auto-reload mode |
| ext_en | input | 1 | Allow `ext_pin` falling edges to set the external flag |
| baud_en | input | 1 | Baud generation mode |
| clkout_en | input | 1 | Clock output mode (needs `cnt_sel` low) |
| cnt_pin | input | 1 | External count input |
| ext_pin | input | 1 | External direction / event input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External flag / 17th count bit |
| baud_tick | output | 1 | One-clock pulse per baud-mode rollover |
| clk_out | output | 1 | 50% duty clock output |

## Verification
The divided-clock rate is swept over run lengths that differ by less than one prescale period. This tells a divide-by-12 from any neighbouring divisor, and it catches a counter that runs while stopped.

Baud and clock-out are run together over a sweep of reload values near all-ones. Baud tick spacing and clock-out half-periods are measured against (65536 - reload) * 2, which separates a wrong reload value, an off-by-one at the wrap and a wrong fast-mode rate.

Up/down runs cover both directions:
- From above the reload value, the count falls to it.
- From all-ones, the count rises and wraps.

Both show the asymmetric reload targets and the external flag toggling twice.

Pin-driven cases cover two things:
- Counted edges, with the run bit both set and clear.
- An external-pin fall with its enable both set and clear, which separates setting the flag from reloading the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        REG_CNT_LO = 3'd0,
        REG_CNT_HI = 3'd1,
        REG_RLD_LO = 3'd2,
        REG_RLD_HI = 3'd3,
        REG_FLAGS  = 3'd4
    } tmr_reg_e;

    localparam int FLAG_OVF_BIT = 0;
    localparam int FLAG_EXT_BIT = 1;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic prev
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 3'b111;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[1];
    assign prev  = sh_q[2];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int MC_DIV = 12,
    parameter int ST_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int MAXD = (MC_DIV > ST_DIV) ? MC_DIV : ST_DIV;
    localparam int PW   = $clog2(MAXD + 1);
    localparam logic [PW-1:0] LIM_SLOW = PW'(MC_DIV - 1);
    localparam logic [PW-1:0] LIM_FAST = PW'(ST_DIV - 1);

    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim   = fast ? LIM_FAST : LIM_SLOW;
        tick  = 1'b0;
        pre_d = pre_q;
        if (!run) begin
            pre_d = '0;
        end else if (pre_q >= lim) begin
            pre_d = '0;
            tick  = 1'b1;
        end else begin
            pre_d = pre_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/mmode_timer16.sv
module mmode_timer16 #(
    parameter int HALF_W = 8,
    parameter int MC_DIV = 12,
    parameter int ST_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cnt_sel,
    input  logic              updn_en,
    input  logic              ext_en,
    input  logic              baud_en,
    input  logic              clkout_en,
    input  logic              cnt_pin,
    input  logic              ext_pin,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [HALF_W-1:0] rd_data,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              baud_tick,
    output logic              clk_out
);
    import tmr_pkg::*;

    localparam int CNT_W   = 2 * HALF_W;
    localparam int NPINS   = 2;
    localparam int PIN_CNT = 0;
    localparam int PIN_EXT = 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             ovf;
        logic             ext;
        logic             btick;
        logic             cko;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    // Pin synchronizers: one per external input
    logic [NPINS-1:0] pin_vec, lvl_vec, prv_vec, fall_vec;
    assign pin_vec[PIN_CNT] = cnt_pin;
    assign pin_vec[PIN_EXT] = ext_pin;

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_sync
        tmr_edge_sync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_vec[gi]),
            .level (lvl_vec[gi]),
            .prev  (prv_vec[gi])
        );
        assign fall_vec[gi] = prv_vec[gi] & ~lvl_vec[gi];
    end

    // Mode decode
    logic cko_act, fast_mode, updn_act, pre_tick, step;
    assign cko_act   = clkout_en & ~cnt_sel;
    assign fast_mode = baud_en | cko_act;
    assign updn_act  = updn_en & ~fast_mode;

    tmr_prescale #(
        .MC_DIV (MC_DIV),
        .ST_DIV (ST_DIV)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_en & ~cnt_sel),
        .fast  (fast_mode),
        .tick  (pre_tick)
    );

    assign step = run_en & (cnt_sel ? fall_vec[PIN_CNT] : pre_tick);

    always_comb begin
        st_d       = st_q;
        st_d.btick = 1'b0;

        if (step) begin
            if (updn_act && !lvl_vec[PIN_EXT]) begin
                // down count: wrap at reload value to all-ones
                if (st_q.cnt == st_q.rld) begin
                    st_d.cnt = '1;
                    st_d.ovf = 1'b1;
                    st_d.ext = ~st_q.ext;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end else if (st_q.cnt == {CNT_W{1'b1}}) begin
                st_d.cnt = st_q.rld;
                if (fast_mode) begin
                    st_d.btick = baud_en;
                    if (cko_act) st_d.cko = ~st_q.cko;
                end else begin
                    st_d.ovf = 1'b1;
                    if (updn_act) st_d.ext = ~st_q.ext;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end

        if (ext_en && !updn_act && fall_vec[PIN_EXT]) begin
            st_d.ext = 1'b1;
        end

        if (wr_en) begin
            case (wr_addr)
                REG_CNT_LO: st_d.cnt[HALF_W-1:0]     = wr_data;
                REG_CNT_HI: st_d.cnt[CNT_W-1:HALF_W] = wr_data;
                REG_RLD_LO: st_d.rld[HALF_W-1:0]     = wr_data;
                REG_RLD_HI: st_d.rld[CNT_W-1:HALF_W] = wr_data;
                REG_FLAGS: begin
                    st_d.ovf = wr_data[FLAG_OVF_BIT];
                    st_d.ext = wr_data[FLAG_EXT_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CNT_LO: rd_data = st_q.cnt[HALF_W-1:0];
            REG_CNT_HI: rd_data = st_q.cnt[CNT_W-1:HALF_W];
            REG_RLD_LO: rd_data = st_q.rld[HALF_W-1:0];
            REG_RLD_HI: rd_data = st_q.rld[CNT_W-1:HALF_W];
            REG_FLAGS: begin
                rd_data[FLAG_OVF_BIT] = st_q.ovf;
                rd_data[FLAG_EXT_BIT] = st_q.ext;
            end
            default: rd_data = '0;
        endcase
    end

    assign ovf_flag  = st_q.ovf;
    assign ext_flag  = st_q.ext;
    assign baud_tick = st_q.btick;
    assign clk_out   = st_q.cko;
endmodule

// File: rtl/mmode_timer16_chk.sv
module mmode_timer16_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             cnt_sel,
    input logic             baud_en,
    input logic             clkout_en,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic             ovf_flag,
    input logic             baud_tick,
    input logic             clk_out,
    input logic [CNT_W-1:0] cnt
);
    assert_frozen_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> $stable(cnt));

    assert_no_ovf_in_baud_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_en && !ovf_flag && !(wr_en && wr_addr == 3'd4)) |=> !ovf_flag);

    assert_tick_needs_baud_R8: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(baud_en));

    assert_cko_only_when_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out != $past(clk_out)) |-> $past(clkout_en && !cnt_sel));

    assert_ovf_rise_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_flag) && !$past(wr_en)) |->
            $past(run_en && !baud_en && !(clkout_en && !cnt_sel)));
endmodule

bind mmode_timer16 mmode_timer16_chk #(.CNT_W(2 * HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cnt_sel   (cnt_sel),
    .baud_en   (baud_en),
    .clkout_en (clkout_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ovf_flag  (ovf_flag),
    .baud_tick (baud_tick),
    .clk_out   (clk_out),
    .cnt       (st_q.cnt)
);

// File: tb/mmode_timer16_bench.sv
`timescale 1ns/1ps
module mmode_timer16_bench;
    localparam int HALF_W = 8;
    localparam int MC_DIV = 12;
    localparam int ST_DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 0, cnt_sel = 0, updn_en = 0, ext_en = 0, baud_en = 0, clkout_en = 0;
    logic cnt_pin = 1, ext_pin = 1, wr_en = 0;
    logic [2:0] wr_addr = 0, rd_addr = 0;
    logic [HALF_W-1:0] wr_data = 0;
    logic [HALF_W-1:0] rd_data;
    logic ovf_flag, ext_flag, baud_tick, clk_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    mmode_timer16 #(.HALF_W(HALF_W), .MC_DIV(MC_DIV), .ST_DIV(ST_DIV)) u_mmode_timer16 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_sel(cnt_sel), .updn_en(updn_en),
        .ext_en(ext_en), .baud_en(baud_en), .clkout_en(clkout_en), .cnt_pin(cnt_pin),
        .ext_pin(ext_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
        .baud_tick(baud_tick), .clk_out(clk_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wr16(input logic [2:0] a_lo, input int v);
        wr(a_lo, v[7:0]);
        wr(a_lo + 3'd1, v[15:8]);
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic rd16(input logic [2:0] a_lo, output int v);
        int lo, hi;
        rd(a_lo, lo);
        rd(a_lo + 3'd1, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic run_for(input int n);
        @(negedge clk);
        run_en = 1;
        repeat (n) @(negedge clk);
        run_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // gap in clocks between two consecutive events (baud pulse or clk_out edge)
    task automatic gap(input bit use_cko, output int g);
        logic prev;
        int n;
        prev = clk_out;
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!(use_cko ? (clk_out != prev) : baud_tick) && n < 5000);
        prev = clk_out;
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!(use_cko ? (clk_out != prev) : baud_tick) && n < 5000);
        g = n;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v, g;
        idle(5);
        rst_n = 1;
        idle(2);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 reset baud_tick", int'(baud_tick), 0);
        chk("R1 reset clk_out", int'(clk_out), 0);

        // R2 register access
        wr16(3'd2, 16'h3CA5);
        rd(3'd2, v); chk("R2 reload low", v, 16'hA5);
        rd(3'd3, v); chk("R2 reload high", v, 16'h3C);
        wr16(3'd0, 16'h3412);
        rd16(3'd0, v); chk("R2 count word", v, 16'h3412);
        wr(3'd4, 8'h03);
        rd(3'd4, v); chk("R2 flags write", v, 3);
        wr(3'd4, 8'h00);

        // R3 divide by 12 sweep, stop freezes
        for (int k = 1; k <= 6; k++) begin
            wr16(3'd0, 0);
            run_for(MC_DIV * k + MC_DIV - 1);
            rd16(3'd0, v); chk("R3 timer rate", v, k);
        end
        idle(50);
        rd16(3'd0, v); chk("R3 frozen while stopped", v, 6);

        // R7 state-rate counting
        wr16(3'd2, 0);
        wr16(3'd0, 0);
        baud_en = 1;
        run_for(40);
        rd16(3'd0, v); chk("R7 baud rate count", v, 40 / ST_DIV);
        baud_en = 0;

        // R4 external count pin
        cnt_sel = 1;
        wr16(3'd0, 0);
        @(negedge clk); run_en = 1;
        for (int p = 0; p < 7; p++) begin
            cnt_pin = 0; idle(3);
            cnt_pin = 1; idle(3);
        end
        idle(4);
        run_en = 0;
        rd16(3'd0, v); chk("R4 counted edges", v, 7);
        for (int p = 0; p < 3; p++) begin
            cnt_pin = 0; idle(3);
            cnt_pin = 1; idle(3);
        end
        idle(4);
        rd16(3'd0, v); chk("R4 edges ignored when stopped", v, 7);
        cnt_sel = 0;

        // R5 auto-reload up
        wr(3'd4, 0);
        wr16(3'd2, 16'hFFF8);
        wr16(3'd0, 16'hFFFE);
        run_for(2 * MC_DIV);
        rd16(3'd0, v); chk("R5 reload after rollover", v, 16'hFFF8);
        rd(3'd4, v); chk("R5 overflow flag set", v, 1);
        run_for(8 * MC_DIV);
        rd16(3'd0, v); chk("R5 second rollover", v, 16'hFFF8);
        rd(3'd4, v); chk("R5 external flag untouched", v, 1);
        wr(3'd4, 0);

        // R6 up/down
        ext_pin = 0; updn_en = 1;
        idle(5);
        wr16(3'd2, 16'h0100);
        wr16(3'd0, 16'h0103);
        run_for(3 * MC_DIV);
        rd16(3'd0, v); chk("R6 down to reload", v, 16'h0100);
        rd(3'd4, v); chk("R6 no flag before underflow", v, 0);
        run_for(MC_DIV);
        rd16(3'd0, v); chk("R6 underflow loads all-ones", v, 16'hFFFF);
        rd(3'd4, v); chk("R6 underflow flags", v, 3);
        ext_pin = 1; idle(5);
        run_for(MC_DIV);
        rd16(3'd0, v); chk("R6 up rollover reload", v, 16'h0100);
        rd(3'd4, v); chk("R6 ext toggled back", v, 1);
        updn_en = 0;
        wr(3'd4, 0);

        // R8 R9 baud and clock-out sweep, shared reload
        baud_en = 1; clkout_en = 1;
        for (int r = 16'hFFF0; r <= 16'hFFFE; r += 2) begin
            wr16(3'd2, r);
            wr16(3'd0, r);
            @(negedge clk); run_en = 1;
            gap(1'b0, g); chk("R8 baud tick period", g, (65536 - r) * ST_DIV);
            gap(1'b1, g); chk("R9 clock-out half period", g, (65536 - r) * ST_DIV);
            run_en = 0;
        end
        rd(3'd4, v); chk("R7 no overflow in fast modes", v, 0);
        clkout_en = 0;

        // R10 external edge in baud mode
        wr16(3'd0, 16'h1234);
        ext_en = 0;
        ext_pin = 0; idle(6);
        rd(3'd4, v); chk("R10 edge ignored without enable", v, 0);
        ext_pin = 1; idle(6);
        ext_en = 1;
        ext_pin = 0; idle(6);
        rd(3'd4, v); chk("R10 edge sets external flag", v, 2);
        rd16(3'd0, v); chk("R10 no reload on edge", v, 16'h1234);
        baud_en = 0; ext_en = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule